// File: doc/BRIEF.md
# Systolic Pipelined FIR Filter

This block is a fixed-coefficient FIR filter built for high clock rates. It takes one signed sample per clock, qualified by a valid strobe, and returns one filtered, scaled and clamped signed result per clock after a constant latency. Coefficients are fixed when the design is elaborated and are given as one packed vector.

Every tap owns a signed multiplier. Both operands are registered, and so is the product. The tap sums are passed along a chain of registered adders: each tap adds its product to the registered partial sum from the tap before it. No path therefore carries more than a single 48-bit addition between registers. The sample delay line gives each tap two register stages (one for the first tap). This keeps each sample in step with the one-cycle delay of the partial sum, so the result equals a direct-form convolution. The final sum is arithmetically shifted right and clamped to the output width.

Top module: `fir_systolic`

## Requirements
- R1: Each tap forms the signed product of an 18-bit coefficient and a 25-bit sample. Products and partial sums are kept as 48-bit signed values, so full-scale negative samples and coefficients (-2^24, -2^17) produce exact sums before output scaling.
- R2: The chain result for the sample presented in clock n is the sum over k of c_k·x(n−k). Here c_k is bits [k*COEF_W +: COEF_W] of `COEFS` and x(n) is the sample presented in clock n. A clock with `in_valid` low contributes zero, whatever `in_data` holds.
- R3: A sample presented before rising edge e shows up on `out_data` after edge e+NUM_TAPS+2. The latency is NUM_TAPS+3 edges, counting the edge that captures the sample.
- R4: `out_valid` is `in_valid` delayed by the same NUM_TAPS+3 edges.
- R5: When it is in range, `out_data` is the chain result arithmetically shifted right by `SHIFT` (rounding toward minus infinity), truncated to OUT_W bits.
- R6: A shifted result above 2^(OUT_W−1)−1 gives exactly 2^(OUT_W−1)−1. A shifted result below −2^(OUT_W−1) gives exactly −2^(OUT_W−1).
- R7: `rst` is synchronous and active high. The edge at which it is sampled high clears every data and valid register, so `out_valid` and `out_data` read 0 after that edge. Samples presented before the reset never reach the output afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_data` in this clock |
| in_data | input | DATA_W (25) | Signed input sample |
| out_valid | output | 1 | Marks a result that belongs to a valid sample |
| out_data | output | OUT_W (16) | Scaled and clamped signed result |

## Verification
The assertions assume that `rst` is held high for at least one rising edge before any check matters. They also assume that `in_valid` and `in_data` are driven to known values at every edge, because an invalid sample is still carried as a zero through the delay line. The bench sets every input at the falling edge. It keeps `in_valid` low during reset and through the final flush, and it draws every sample from the signed 25-bit range, including both extremes. This keeps every partial sum inside the 48-bit accumulator that the sign and clamp properties depend on.

// File: rtl/fir_sys_pkg.sv
package fir_sys_pkg;

  // Width of every product and partial sum in the cascade.
  localparam int unsigned ACC_W = 48;

  // Arithmetic right shift followed by a clamp to a signed ow-bit range,
  // returned sign-extended to the accumulator width.
  function automatic logic signed [ACC_W-1:0] scale_clamp(
    input logic signed [ACC_W-1:0] acc,
    input int unsigned             sh,
    input int unsigned             ow
  );
    logic signed [ACC_W-1:0] shifted;
    logic signed [ACC_W-1:0] top;
    logic signed [ACC_W-1:0] bottom;
    shifted = acc >>> sh;
    top     = ({{(ACC_W-1){1'b0}}, 1'b1} << (ow - 1)) - {{(ACC_W-1){1'b0}}, 1'b1};
    bottom  = ~top;
    if (shifted > top)         return top;
    else if (shifted < bottom) return bottom;
    else                       return shifted;
  endfunction

endpackage

// File: rtl/fir_sys_tap.sv
module fir_sys_tap
  import fir_sys_pkg::*;
#(
  parameter int unsigned              DATA_W = 25,
  parameter int unsigned              COEF_W = 18,
  parameter bit                       FIRST  = 1'b0,
  parameter logic signed [COEF_W-1:0] COEF   = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic                     xv_i,
  input  logic signed [ACC_W-1:0]  sum_i,
  output logic signed [DATA_W-1:0] x_o,
  output logic                     xv_o,
  output logic signed [ACC_W-1:0]  sum_o
);
  localparam int unsigned PROD_W = COEF_W + DATA_W;

  logic signed [DATA_W-1:0] op_x;
  logic                     op_v;
  logic signed [COEF_W-1:0] coef_r;
  logic signed [PROD_W-1:0] mult_w;
  logic signed [ACC_W-1:0]  prod_r;
  logic signed [ACC_W-1:0]  sum_r;

  // Sample delay: one stage for the first tap, two for the rest.
  generate
    if (FIRST) begin : g_one_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          op_x <= '0;
          op_v <= 1'b0;
        end else begin
          op_x <= x_i;
          op_v <= xv_i;
        end
      end
    end else begin : g_two_stage
      logic signed [DATA_W-1:0] mid_x;
      logic                     mid_v;
      always_ff @(posedge clk) begin
        if (rst) begin
          mid_x <= '0;
          mid_v <= 1'b0;
          op_x  <= '0;
          op_v  <= 1'b0;
        end else begin
          mid_x <= x_i;
          mid_v <= xv_i;
          op_x  <= mid_x;
          op_v  <= mid_v;
        end
      end
    end
  endgenerate

  assign mult_w = coef_r * op_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      coef_r <= '0;
      prod_r <= '0;
      sum_r  <= '0;
    end else begin
      coef_r <= COEF;
      prod_r <= {{(ACC_W-PROD_W){mult_w[PROD_W-1]}}, mult_w};
      sum_r  <= sum_i + prod_r;
    end
  end

  assign x_o   = op_x;
  assign xv_o  = op_v;
  assign sum_o = sum_r;

  // R1: the registered product carries the sign of operand times coefficient.
  p_prod_sign_r1: assert property (@(posedge clk) disable iff (rst)
    (op_x != '0 && coef_r != '0) |=>
      prod_r[ACC_W-1] == ($past(op_x[DATA_W-1]) ^ COEF[COEF_W-1]));

  // R2: an invalid sample slot produces no product.
  p_gap_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !op_v |=> prod_r == '0);

endmodule

// File: rtl/fir_sys_out.sv
module fir_sys_out
  import fir_sys_pkg::*;
#(
  parameter int unsigned OUT_W = 16,
  parameter int unsigned SHIFT = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ACC_W-1:0] acc_i,
  output logic signed [OUT_W-1:0] y_o
);
  localparam logic signed [OUT_W-1:0] HI_OUT = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] LO_OUT = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] HI_ACC = {{(ACC_W-OUT_W){1'b0}}, HI_OUT};
  localparam logic signed [ACC_W-1:0] LO_ACC = {{(ACC_W-OUT_W){1'b1}}, LO_OUT};

  logic signed [ACC_W-1:0] scaled_w;
  logic signed [ACC_W-1:0] shifted_w;
  logic                    over_hi_w;
  logic                    over_lo_w;

  assign scaled_w  = scale_clamp(acc_i, SHIFT, OUT_W);
  assign shifted_w = acc_i >>> SHIFT;
  assign over_hi_w = shifted_w > HI_ACC;
  assign over_lo_w = shifted_w < LO_ACC;

  always_ff @(posedge clk) begin
    if (rst) y_o <= '0;
    else     y_o <= scaled_w[OUT_W-1:0];
  end

  p_sat_hi_r6: assert property (@(posedge clk) disable iff (rst)
    over_hi_w |=> y_o == HI_OUT);

  p_sat_lo_r6: assert property (@(posedge clk) disable iff (rst)
    over_lo_w |=> y_o == LO_OUT);

  p_pass_r5: assert property (@(posedge clk) disable iff (rst)
    (!over_hi_w && !over_lo_w) |=> y_o == $past(shifted_w[OUT_W-1:0]));

endmodule

// File: rtl/fir_systolic.sv
module fir_systolic
  import fir_sys_pkg::*;
#(
  parameter int unsigned NUM_TAPS = 4,
  parameter int unsigned DATA_W   = 25,
  parameter int unsigned COEF_W   = 18,
  parameter int unsigned OUT_W    = 16,
  parameter int unsigned SHIFT    = 8,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS =
    {18'h20000, 18'h003E8, 18'h3FFFB, 18'h00003}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_data
);
  // operand reg + product reg + one sum reg per tap + output reg
  localparam int unsigned LAT = NUM_TAPS + 3;

  logic signed [DATA_W-1:0] x_chain [NUM_TAPS+1];
  logic                     v_chain [NUM_TAPS+1];
  logic signed [ACC_W-1:0]  s_chain [NUM_TAPS+1];
  logic [LAT-1:0]           vld_sr;

  // Invalid slots enter the delay line as zero samples.
  assign x_chain[0] = in_valid ? in_data : '0;
  assign v_chain[0] = in_valid;
  assign s_chain[0] = '0;

  generate
    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
      fir_sys_tap #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .FIRST  (k == 0),
        .COEF   (COEFS[k*COEF_W +: COEF_W])
      ) u_tap (
        .clk   (clk),
        .rst   (rst),
        .x_i   (x_chain[k]),
        .xv_i  (v_chain[k]),
        .sum_i (s_chain[k]),
        .x_o   (x_chain[k+1]),
        .xv_o  (v_chain[k+1]),
        .sum_o (s_chain[k+1])
      );
    end
  endgenerate

  fir_sys_out #(
    .OUT_W (OUT_W),
    .SHIFT (SHIFT)
  ) u_out (
    .clk   (clk),
    .rst   (rst),
    .acc_i (s_chain[NUM_TAPS]),
    .y_o   (out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) vld_sr <= '0;
    else     vld_sr <= {vld_sr[LAT-2:0], in_valid};
  end
  assign out_valid = vld_sr[LAT-1];

  // R2: an invalid slot stays a zero sample all the way to the last tap.
  p_tail_gap_r2: assert property (@(posedge clk) disable iff (rst)
    !v_chain[NUM_TAPS] |-> x_chain[NUM_TAPS] == '0);

  // R7: the edge after a reset cycle leaves the output cleared.
  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> (out_valid == 1'b0 && out_data == '0));

endmodule

// File: tb/tb_fir_systolic.sv
module tb_fir_systolic;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_TAPS   = 4;
  localparam int DATA_W     = 25;
  localparam int OUT_W      = 16;
  localparam int SHIFT      = 8;
  localparam int LAT        = NUM_TAPS + 3;
  localparam int MAX_STEPS  = 512;
  localparam int N_STIM     = 34;
  localparam logic [NUM_TAPS*18-1:0] TB_COEFS =
    {18'h20000, 18'h003E8, 18'h3FFFB, 18'h00003};
  localparam longint CO [NUM_TAPS] = '{3, -5, 1000, -131072};

  localparam int FS_NEG = -16777216;
  localparam int FS_POS = 16777215;
  localparam int STIM_X [N_STIM] = '{
    1000, 0, 0, 0, 0, 0,
    500, 500, 500, 500, 500, 500,
    7777, 7777, 300, -300,
    FS_NEG, FS_NEG, FS_NEG, FS_NEG, FS_NEG,
    FS_POS, FS_POS, FS_POS,
    FS_NEG, FS_POS, FS_NEG, FS_POS,
    1, -1, 2, -2, 0, 0};
  localparam bit STIM_V [N_STIM] = '{
    1, 1, 1, 1, 1, 1,
    1, 1, 1, 1, 1, 1,
    0, 0, 1, 1,
    1, 1, 1, 1, 1,
    1, 1, 1,
    1, 1, 1, 1,
    1, 1, 1, 1, 1, 1};

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic                     in_valid = 1'b0;
  logic signed [DATA_W-1:0] in_data = '0;
  logic                     out_valid;
  logic signed [OUT_W-1:0]  out_data;

  int     n_tests = 0;
  int     n_fail  = 0;
  int     s_idx   = 0;
  longint hist  [NUM_TAPS];
  longint exp_d [MAX_STEPS];
  bit     exp_v [MAX_STEPS];
  string  exp_t [MAX_STEPS];

  always #(CLK_PERIOD/2) clk = ~clk;

  fir_systolic #(
    .NUM_TAPS (NUM_TAPS), .DATA_W (DATA_W), .COEF_W (18),
    .OUT_W (OUT_W), .SHIFT (SHIFT), .COEFS (TB_COEFS)
  ) dut (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_data (in_data),
    .out_valid (out_valid), .out_data (out_data)
  );

  task automatic chk(input string req, input longint act, input longint expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic clear_model();
    for (int j = 0; j < NUM_TAPS; j++) hist[j] = 0;
    s_idx = 0;
  endtask

  // Compare the outputs now visible, then present the next sample.
  task automatic step(input bit v, input int d, input string tag);
    longint y;
    longint q;
    string  t;
    @(negedge clk);
    if (s_idx >= LAT) begin
      chk("R4 valid delay", longint'(out_valid), longint'(exp_v[s_idx-LAT]));
      chk(exp_t[s_idx-LAT], longint'(out_data), exp_d[s_idx-LAT]);
    end else begin
      chk("R4 valid before first result", longint'(out_valid), 0);
      chk("R7 cleared pipeline", longint'(out_data), 0);
    end
    in_valid = v;
    in_data  = DATA_W'(d);
    for (int j = NUM_TAPS - 1; j > 0; j--) hist[j] = hist[j-1];
    hist[0] = v ? longint'(d) : 0;
    y = 0;
    for (int j = 0; j < NUM_TAPS; j++) y += CO[j] * hist[j];
    q = y >>> SHIFT;
    t = tag;
    if (q > 32767) begin
      q = 32767;
      t = "R6 clamp high";
    end else if (q < -32768) begin
      q = -32768;
      t = "R6 clamp low";
    end
    exp_d[s_idx] = q;
    exp_v[s_idx] = v;
    exp_t[s_idx] = t;
    s_idx++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst      = 1'b1;
    in_valid = 1'b0;
    in_data  = '0;
    @(negedge clk);
    chk("R7 reset clears valid", longint'(out_valid), 0);
    chk("R7 reset clears data", longint'(out_data), 0);
    rst = 1'b0;
    clear_model();
  endtask

  task automatic flush();
    for (int j = 0; j < LAT + NUM_TAPS; j++) step(1'b0, 0, "R2 drain");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] st;
    int          first_seen;
    do_reset();

    // Vector table walk: impulse, step, gaps, full-scale values.
    for (int i = 0; i < N_STIM; i++)
      step(STIM_V[i], STIM_X[i], (i >= 16 && i < 28) ? "R1 full scale" : "R2/R5 convolution");
    flush();

    // R3: an impulse after reset first appears exactly LAT steps later.
    do_reset();
    first_seen = -1;
    step(1'b1, 1000, "R3 impulse");
    for (int j = 1; j <= LAT + 2; j++) begin
      step(1'b0, 0, "R3 impulse tail");
      if (out_valid && first_seen < 0) first_seen = j;
    end
    chk("R3 latency in steps", first_seen, LAT);
    flush();

    // Pseudo-random stream with a reset in the middle.
    st = 32'h1234_5678;
    for (int i = 0; i < 80; i++) begin
      int d;
      st = st ^ (st << 13);
      st = st ^ (st >> 17);
      st = st ^ (st << 5);
      d = {{7{st[24]}}, st[24:0]};
      if (st[31:29] == 3'b000) d = FS_NEG;
      if (i == 40) do_reset();
      step(st[27] | st[28], d, "R2/R5 random");
    end
    flush();

    // R2: junk on in_data with in_valid low leaves the output at zero.
    do_reset();
    for (int i = 0; i < 6; i++) step(1'b0, FS_NEG, "R2 ignored data");
    flush();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule